// File: doc/BRIEF.md
# Interrupt Pending Priority Selector

This block decides, in a single combinational pass, whether a hart must take an interrupt right now and, if so, which one. It receives the pending-interrupt vector, the interrupt-enable vector, the delegation mask, the current privilege level and the two global enable bits: one for machine level and one for supervisor level. It returns a take flag and a cause word that names the chosen line.

The block first forms the candidate set: each line that is both pending and enabled. It then splits the candidates by their delegation bit. Each group passes a gate of its own, and that gate depends on the current privilege. The lowest-numbered line among the survivors is reported.

The block holds no state and has no clock. It sits beside the trap-entry logic, which samples the outputs when it needs them. No data streams through it, so every pin is a plain level and there is no handshake.

Top module: `irq_select`

## Requirements
- R1: A line is a candidate only when both its pending bit and its enable bit are 1. A line with either bit at 0 is never reported.
- R2: A candidate whose delegation bit is 0 passes whenever the privilege encoding is below 3 (values 0, 1 and 2), whatever the machine global enable is.
- R3: At privilege 3 (machine), a candidate whose delegation bit is 0 passes only when the machine global enable is 1.
- R4: A candidate whose delegation bit is 1 passes at privilege 0 (user) whatever the supervisor global enable is. At privilege 1 (supervisor) it passes only when the supervisor global enable is 1.
- R5: A candidate whose delegation bit is 1 never passes at privilege 2 or 3, whatever either global enable is.
- R6: When several lines pass, the line with the lowest index is selected.
- R7: When no line passes, `take_o` is 0 and `cause_o` is all zeros.
- R8: When a line is selected, `take_o` is 1. `cause_o` then has bit 31 set as the interrupt flag, the line index in bits 3:0, and every other bit 0.
- R9: The outputs follow the inputs combinationally, with no clock edge between a change of input and the updated result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pend_i | input | 16 | Pending bit of each interrupt line |
| ena_i | input | 16 | Enable bit of each interrupt line |
| deleg_i | input | 16 | 1 = line delegated to supervisor level |
| priv_i | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine (2 treated as between them) |
| mie_glb_i | input | 1 | Machine-level global interrupt enable |
| sie_glb_i | input | 1 | Supervisor-level global interrupt enable |
| take_o | output | 1 | An interrupt must be taken now |
| cause_o | output | 32 | Interrupt flag in bit 31, selected line index in the low bits |

## Verification
The assertions take for granted that every input is a known 0 or 1 whenever it is evaluated. The privilege value may be any of the four encodings, including the unused value 2. The bench drives only known values: a fixed zero pattern before the first case, then directed cases, then uniformly random words for every input, including all privilege values. The random part therefore covers the reserved encoding and dense, overlapping patterns of pending and delegation bits.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;
  typedef enum logic [1:0] {
    PRIV_USER  = 2'd0,
    PRIV_SUPER = 2'd1,
    PRIV_RSVD  = 2'd2,
    PRIV_MACH  = 2'd3
  } priv_e;

  function automatic logic below_mach(input priv_e p);
    return p != PRIV_MACH;
  endfunction
endpackage

// File: rtl/irq_gate.sv
module irq_gate
  import irq_sel_pkg::*;
#(
  parameter int NLINES = 16
) (
  input  logic [NLINES-1:0] cand_i,
  input  logic [NLINES-1:0] deleg_i,
  input  priv_e             priv_i,
  input  logic              mie_glb_i,
  input  logic              sie_glb_i,
  output logic [NLINES-1:0] pass_o
);
  logic mach_ok;
  logic super_ok;

  always_comb begin
    mach_ok  = below_mach(priv_i) || mie_glb_i;
    super_ok = (priv_i == PRIV_USER) || ((priv_i == PRIV_SUPER) && sie_glb_i);
  end

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    assign pass_o[g] = cand_i[g] & (deleg_i[g] ? super_ok : mach_ok);
  end

  always_comb begin
    // R3
    mach_masked_chk: assert ((priv_i != PRIV_MACH) || mie_glb_i ||
                             ((pass_o & ~deleg_i) == '0))
      else $error("non-delegated line passed in machine mode with global enable off");
    // R5
    deleg_blocked_chk: assert (!((priv_i == PRIV_MACH) || (priv_i == PRIV_RSVD)) ||
                               ((pass_o & deleg_i) == '0))
      else $error("delegated line passed above supervisor");
    // R1
    subset_chk: assert ((pass_o & ~cand_i) == '0)
      else $error("line passed without being a candidate");
  end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int NLINES = 16,
  localparam int IDX_W = (NLINES > 1) ? $clog2(NLINES) : 1
) (
  input  logic [NLINES-1:0] vec_i,
  output logic              found_o,
  output logic [IDX_W-1:0]  idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = NLINES - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
  end

  always_comb begin
    // R6
    lowest_wins_chk: assert (!found_o ||
                             (vec_i[idx_o] && ((vec_i & ((NLINES'(1) << idx_o) - NLINES'(1))) == '0)))
      else $error("selected line is not the lowest set bit");
    // R7
    none_found_chk: assert (found_o || (vec_i == '0))
      else $error("set bit present but nothing found");
  end
endmodule

// File: rtl/irq_select.sv
module irq_select
  import irq_sel_pkg::*;
#(
  parameter int NLINES  = 16,
  parameter int CAUSE_W = 32
) (
  input  logic [NLINES-1:0]  pend_i,
  input  logic [NLINES-1:0]  ena_i,
  input  logic [NLINES-1:0]  deleg_i,
  input  logic [1:0]         priv_i,
  input  logic               mie_glb_i,
  input  logic               sie_glb_i,
  output logic               take_o,
  output logic [CAUSE_W-1:0] cause_o
);
  localparam int IDX_W = (NLINES > 1) ? $clog2(NLINES) : 1;

  logic [NLINES-1:0] cand;
  logic [NLINES-1:0] pass;
  logic [IDX_W-1:0]  sel_idx;
  logic              found;

  assign cand = pend_i & ena_i;

  irq_gate #(.NLINES(NLINES)) u_gate (
    .cand_i    (cand),
    .deleg_i   (deleg_i),
    .priv_i    (priv_e'(priv_i)),
    .mie_glb_i (mie_glb_i),
    .sie_glb_i (sie_glb_i),
    .pass_o    (pass)
  );

  irq_prio_enc #(.NLINES(NLINES)) u_enc (
    .vec_i   (pass),
    .found_o (found),
    .idx_o   (sel_idx)
  );

  always_comb begin
    take_o  = found;
    cause_o = '0;
    if (found) begin
      cause_o[IDX_W-1:0]   = sel_idx;
      cause_o[CAUSE_W-1]   = 1'b1;
    end
  end

  always_comb begin
    // R8
    cause_flag_chk: assert (!take_o || (cause_o[CAUSE_W-1] && pend_i[cause_o[IDX_W-1:0]] &&
                                        ena_i[cause_o[IDX_W-1:0]]))
      else $error("taken cause does not name a pending enabled line");
    // R7
    idle_cause_chk: assert (take_o || (cause_o == '0))
      else $error("cause not zero while nothing is taken");
  end
endmodule

// File: tb/irq_select_bench.sv
`timescale 1ns/1ps
module irq_select_bench;
  localparam int NL = 16;
  localparam int CW = 32;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [NL-1:0] pend, ena, deleg;
  logic [1:0]    priv;
  logic          mie, sie;
  logic          take;
  logic [CW-1:0] cause;

  irq_select u_irq_select (
    .pend_i(pend), .ena_i(ena), .deleg_i(deleg), .priv_i(priv),
    .mie_glb_i(mie), .sie_glb_i(sie), .take_o(take), .cause_o(cause)
  );

  typedef struct {
    logic          take;
    logic [CW-1:0] cause;
    string         req;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  function automatic exp_t ref_model(input logic [NL-1:0] p, input logic [NL-1:0] e,
                                     input logic [NL-1:0] d, input logic [1:0] pr,
                                     input logic m, input logic s, input string tag);
    exp_t r;
    r.take = 1'b0; r.cause = '0; r.req = tag;
    for (int i = 0; i < NL; i++) begin
      logic ok;
      ok = d[i] ? ((pr == 2'd0) || (pr == 2'd1 && s)) : ((pr != 2'd3) || m);
      if (p[i] && e[i] && ok && !r.take) begin
        r.take = 1'b1;
        r.cause = 32'h8000_0000 | CW'(i);
      end
    end
    return r;
  endfunction

  task automatic drive(input logic [NL-1:0] p, input logic [NL-1:0] e,
                       input logic [NL-1:0] d, input logic [1:0] pr,
                       input logic m, input logic s, input string tag);
    @(posedge clk);
    pend = p; ena = e; deleg = d; priv = pr; mie = m; sie = s;
    q.push_back(ref_model(p, e, d, pr, m, s, tag));
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t x;
      x = q.pop_front();
      checks++;
      if (take !== x.take || cause !== x.cause) begin
        fails++;
        $display("FAIL %s: take=%0b cause=%h expected take=%0b cause=%h",
                 x.req, take, cause, x.take, x.cause);
      end
    end
  end

  initial begin
    pend = '0; ena = '0; deleg = '0; priv = 2'd0; mie = 1'b0; sie = 1'b0;
    // R7 idle state
    drive(16'h0000, 16'h0000, 16'h0000, 2'd3, 1'b1, 1'b1, "R7");
    // R1 pending without enable, enable without pending
    drive(16'h00F0, 16'h0F00, 16'h0000, 2'd0, 1'b1, 1'b1, "R1");
    // R2 non-delegated below machine
    drive(16'h0020, 16'h0020, 16'h0000, 2'd0, 1'b0, 1'b0, "R2");
    drive(16'h0020, 16'h0020, 16'h0000, 2'd1, 1'b0, 1'b0, "R2");
    drive(16'h0020, 16'h0020, 16'h0000, 2'd2, 1'b0, 1'b0, "R2");
    // R3 machine mode gating
    drive(16'h0020, 16'h0020, 16'h0000, 2'd3, 1'b0, 1'b1, "R3");
    drive(16'h0020, 16'h0020, 16'h0000, 2'd3, 1'b1, 1'b0, "R3");
    // R4 delegated lines
    drive(16'h0002, 16'h0002, 16'h0002, 2'd0, 1'b0, 1'b0, "R4");
    drive(16'h0002, 16'h0002, 16'h0002, 2'd1, 1'b1, 1'b0, "R4");
    drive(16'h0002, 16'h0002, 16'h0002, 2'd1, 1'b0, 1'b1, "R4");
    // R5 delegated blocked above supervisor
    drive(16'h0002, 16'h0002, 16'h0002, 2'd3, 1'b1, 1'b1, "R5");
    drive(16'h0002, 16'h0002, 16'h0002, 2'd2, 1'b1, 1'b1, "R5");
    drive(16'h0204, 16'hFFFF, 16'h0004, 2'd3, 1'b1, 1'b1, "R5");
    // R6 lowest index wins
    drive(16'h8088, 16'hFFFF, 16'h0000, 2'd0, 1'b0, 1'b0, "R6");
    drive(16'h0006, 16'hFFFF, 16'h0002, 2'd1, 1'b0, 1'b0, "R6");
    // R8 cause field at both ends
    drive(16'h8000, 16'h8000, 16'h0000, 2'd3, 1'b1, 1'b0, "R8");
    drive(16'h0001, 16'h0001, 16'h0000, 2'd3, 1'b1, 1'b0, "R8");
    for (int n = 0; n < 3000; n++) begin
      drive(NL'($urandom), NL'($urandom), NL'($urandom), 2'($urandom),
            1'($urandom), 1'($urandom), "R6");
    end
    @(posedge clk);
    @(posedge clk);
    // R9 result follows input without a clock edge
    @(negedge clk);
    pend = 16'h0400; ena = 16'h0400; deleg = '0; priv = 2'd0; mie = 1'b0; sie = 1'b0;
    #1;
    checks++;
    if (take !== 1'b1 || cause !== 32'h8000_000A) begin
      fails++;
      $display("FAIL R9: take=%0b cause=%h expected take=1 cause=8000000a", take, cause);
    end
    @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule